// File: doc/BRIEF.md
# GPIO pad and interrupt controller

A memory-mapped controller for a small bank of general-purpose pins. Each pin has two 32-bit control words. Together they set:

- whether the pin is in GPIO mode;
- how transmit and receive are gated;
- the output drive value and the pull direction;
- whether the received level is inverted;
- the kind of event that raises an interrupt;
- which of 16 shared interrupt lines the pin feeds.

Pin inputs are synchronized. The synchronized value, possibly inverted, goes through an edge or level detector. Qualified events are steered into a 16-bit sticky status register. That register is ANDed with a 16-bit enable mask and reduced to a single interrupt output.

Software reaches the block through a single-cycle 32-bit register port. A write takes effect at the next clock edge. Read data is a combinational function of the address. Pin control words are grouped in chunks, so a pin's address is computed from its chunk index and its slot within the chunk. The pad side exposes, per pin:

- an input;
- an output value;
- an output enable;
- a pull-up select.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every register reads 0: status (0x300), mask (0x380) and all pin control words. The interrupt output and every output enable are low.
- R2: Control word 0 of pin p is at 0x4400 + (p/15)*0x400 + (p%15)*8. Control word 1 is 4 bytes above it, so pin 14 uses 0x4470 and pin 16 uses 0x4808. A slot at or beyond 15 within a chunk is unmapped: it reads 0 and writes to it change nothing.
- R3: Control word 0 holds these fields, and all other bits read 0:
  - bit 1: output value;
  - bits 10:8: direction mode (0 = TX and RX, 1 = TX only, 2 = RX only, 3..7 = neither);
  - bit 15: GPIO enable;
  - bit 23: pull-up;
  - bits 31:28: interrupt line.

  Bit 0 is read-only. It shows the synchronized input two clocks after the pin changes, and reads 0 unless GPIO is enabled and RX is on.
- R4: The pad output enable is high only when GPIO is enabled and the mode is 0 or 1. The pad output follows bit 1 and the pull-up select follows bit 23.
- R5: With trigger type 2 in control word 1 bits 2:0, a rising qualified input sets the status bit of the pin's line, visible three clocks after the pin changes. A falling input does not set it.
- R6: Trigger type 1 detects falling edges only.
- R7: Trigger type 3 detects both edges.
- R8: Trigger type 4 is level-sensitive. The status bit is set on every cycle the qualified input is high, so a write-1-to-clear during that time leaves it set. Once the input drops, the bit stays set until it is cleared.
- R9: Control word 1 bit 6 inverts the received value before detection. With level mode this gives an active-low interrupt.
- R10: Writing status bits is write-1-to-clear. Writing 0 leaves a bit unchanged.
- R11: The mask is 16 bits wide and a 1 enables its line. The interrupt output is high exactly when some status bit has its mask bit set.
- R12: Pins routed to the same line OR their events into one status bit, and no other status bit changes.
- R13: Trigger type 0, RX disabled (mode 1) or GPIO disabled each suppress all events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 16 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pad_in_i | input | NUM_PINS | Pad input levels |
| pad_out_o | output | NUM_PINS | Pad output values |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| pad_pu_o | output | NUM_PINS | Pull-up select (0 = pull-down) |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
Each detector type is driven with a rising transition followed by a falling one, on a dedicated pin and line. This separates the rising, falling, both-edge and level behaviours, and exposes any swapped polarity. The level pin is held active across a clear to show the reassertion, then released to show the sticky hold. An inverted active-low pin shows that inversion happens before detection. Two pins share one line, first separately and then together, to show the OR and the absence of stray bits. Three suppression cases are tried with an identical input toggle: trigger off, TX-only mode and GPIO disabled.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W       = 16;
  localparam int unsigned DATA_W       = 32;
  localparam logic [15:0] STATUS_ADDR  = 16'h0300;
  localparam logic [15:0] MASK_ADDR    = 16'h0380;
  localparam int unsigned PIN_BASE     = 'h4400;
  localparam int unsigned CHUNK_STRIDE = 'h400;
  localparam int unsigned PIN_STRIDE   = 8;

  localparam logic [2:0] TRIG_OFF   = 3'd0;
  localparam logic [2:0] TRIG_FALL  = 3'd1;
  localparam logic [2:0] TRIG_RISE  = 3'd2;
  localparam logic [2:0] TRIG_BOTH  = 3'd3;
  localparam logic [2:0] TRIG_LEVEL = 3'd4;

  typedef struct packed {
    logic [3:0] line;
    logic       pull_up;
    logic       gpio_en;
    logic [2:0] dir;
    logic       tx_val;
    logic [2:0] trig;
    logic       inv;
  } pin_cfg_t;

  function automatic logic [15:0] pin_word_addr(input int unsigned pin,
                                                input int unsigned per_chunk,
                                                input bit          word1);
    int unsigned a;
    a = PIN_BASE + (pin / per_chunk) * CHUNK_STRIDE
      + (pin % per_chunk) * PIN_STRIDE + (word1 ? 4 : 0);
    return a[15:0];
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_pkg::*;
#(
  parameter int unsigned LINE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr0_i,
  input  logic              wr1_i,
  input  pin_cfg_t          wcfg_i,
  input  logic              rx_i,
  output logic [DATA_W-1:0] ctl0_o,
  output logic [DATA_W-1:0] ctl1_o,
  output logic              ev_o,
  output logic [LINE_W-1:0] line_o,
  output logic              pad_out_o,
  output logic              pad_oe_o,
  output logic              pad_pu_o
);
  logic [LINE_W-1:0] line_q;
  logic       pu_q, en_q, tx_q, inv_q, prev_q;
  logic [2:0] dir_q, trig_q;
  logic       rx_en, tx_en, qual, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      pu_q   <= 1'b0;
      en_q   <= 1'b0;
      dir_q  <= '0;
      tx_q   <= 1'b0;
      trig_q <= TRIG_OFF;
      inv_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      if (wr0_i) begin
        line_q <= wcfg_i.line[LINE_W-1:0];
        pu_q   <= wcfg_i.pull_up;
        en_q   <= wcfg_i.gpio_en;
        dir_q  <= wcfg_i.dir;
        tx_q   <= wcfg_i.tx_val;
      end
      if (wr1_i) begin
        trig_q <= wcfg_i.trig;
        inv_q  <= wcfg_i.inv;
      end
      prev_q <= qual;
    end
  end

  assign rx_en = en_q && (dir_q == 3'd0 || dir_q == 3'd2);
  assign tx_en = en_q && (dir_q == 3'd0 || dir_q == 3'd1);
  assign qual  = rx_i ^ inv_q;

  always_comb begin
    unique case (trig_q)
      TRIG_FALL:  hit = prev_q & ~qual;
      TRIG_RISE:  hit = ~prev_q & qual;
      TRIG_BOTH:  hit = prev_q ^ qual;
      TRIG_LEVEL: hit = qual;
      default:    hit = 1'b0;
    endcase
  end

  assign ev_o      = rx_en & hit;
  assign line_o    = line_q;
  assign pad_out_o = tx_q;
  assign pad_oe_o  = tx_en;
  assign pad_pu_o  = pu_q;

  always_comb begin
    ctl0_o               = '0;
    ctl0_o[0]            = rx_en & rx_i;
    ctl0_o[1]            = tx_q;
    ctl0_o[10:8]         = dir_q;
    ctl0_o[15]           = en_q;
    ctl0_o[23]           = pu_q;
    ctl0_o[28 +: LINE_W] = line_q;
    ctl1_o               = '0;
    ctl1_o[2:0]          = trig_q;
    ctl1_o[6]            = inv_q;
  end

  AST_OE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o |-> (en_q && dir_q[2:1] == 2'b00)); // R4
  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o && trig_q != TRIG_LEVEL) |-> (qual != prev_q)); // R7
  AST_NO_EVENT_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q || trig_q == TRIG_OFF) |-> !ev_o); // R13
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
  parameter int unsigned NUM_PINS  = 30,
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_PINS-1:0]              pin_ev_i,
  input  logic [NUM_PINS-1:0][LINE_W-1:0]  pin_line_i,
  input  logic                             st_wr_i,
  input  logic                             mk_wr_i,
  input  logic [NUM_LINES-1:0]             wdata_i,
  output logic [NUM_LINES-1:0]             status_o,
  output logic [NUM_LINES-1:0]             mask_o,
  output logic                             irq_o
);
  logic [NUM_LINES-1:0] status_q, mask_q, line_ev, clr;

  always_comb begin
    line_ev = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (pin_ev_i[p]) line_ev[pin_line_i[p]] = 1'b1;
  end

  assign clr = st_wr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr) | line_ev; // set wins over clear
      if (mk_wr_i) mask_q <= wdata_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & mask_q);

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_ev != '0) |=> ((status_q & $past(line_ev)) == $past(line_ev))); // R8
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr_i |=> ((status_q & $past(wdata_i & ~line_ev)) == '0)); // R10
  AST_NO_STRAY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(line_ev)) == '0)); // R12
  AST_MASK_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o); // R11
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS       = 30,
  parameter int unsigned PINS_PER_CHUNK = 15,
  parameter int unsigned NUM_LINES      = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_pu_o,
  output logic                irq_o
);
  localparam int unsigned LINE_W = $clog2(NUM_LINES);

  logic [NUM_PINS-1:0]             rx_sync, hit0, hit1, pin_ev;
  logic [NUM_PINS-1:0][LINE_W-1:0] pin_line;
  logic [DATA_W-1:0]               ctl0 [NUM_PINS];
  logic [DATA_W-1:0]               ctl1 [NUM_PINS];
  logic [NUM_LINES-1:0]            status, mask;
  logic                            st_hit, mk_hit;
  pin_cfg_t                        wcfg;

  assign st_hit = (addr_i == STATUS_ADDR);
  assign mk_hit = (addr_i == MASK_ADDR);

  always_comb begin
    wcfg.line    = wdata_i[31:28];
    wcfg.pull_up = wdata_i[23];
    wcfg.gpio_en = wdata_i[15];
    wcfg.dir     = wdata_i[10:8];
    wcfg.tx_val  = wdata_i[1];
    wcfg.trig    = wdata_i[2:0];
    wcfg.inv     = wdata_i[6];
  end

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(rx_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [ADDR_W-1:0] A0 = pin_word_addr(p, PINS_PER_CHUNK, 1'b0);
    localparam logic [ADDR_W-1:0] A1 = pin_word_addr(p, PINS_PER_CHUNK, 1'b1);
    assign hit0[p] = (addr_i == A0);
    assign hit1[p] = (addr_i == A1);

    gpio_pin_cell #(.LINE_W(LINE_W)) u_cell (
      .clk_i, .rst_ni,
      .wr0_i     (wr_en_i & hit0[p]),
      .wr1_i     (wr_en_i & hit1[p]),
      .wcfg_i    (wcfg),
      .rx_i      (rx_sync[p]),
      .ctl0_o    (ctl0[p]),
      .ctl1_o    (ctl1[p]),
      .ev_o      (pin_ev[p]),
      .line_o    (pin_line[p]),
      .pad_out_o (pad_out_o[p]),
      .pad_oe_o  (pad_oe_o[p]),
      .pad_pu_o  (pad_pu_o[p])
    );
  end

  gpio_irq_agg #(.NUM_PINS(NUM_PINS), .NUM_LINES(NUM_LINES)) u_agg (
    .clk_i, .rst_ni,
    .pin_ev_i   (pin_ev),
    .pin_line_i (pin_line),
    .st_wr_i    (wr_en_i & st_hit),
    .mk_wr_i    (wr_en_i & mk_hit),
    .wdata_i    (wdata_i[NUM_LINES-1:0]),
    .status_o   (status),
    .mask_o     (mask),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (st_hit) rdata_o[NUM_LINES-1:0] = status;
    if (mk_hit) rdata_o[NUM_LINES-1:0] = mask;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (hit0[p]) rdata_o = ctl0[p];
      if (hit1[p]) rdata_o = ctl1[p];
    end
  end

  AST_ONE_PIN_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit0, hit1, st_hit, mk_hit})); // R2
  AST_MASK_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (mask != '0)); // R1
endmodule

// File: tb/gpio_ctrl_test.sv
module gpio_ctrl_test;
  import gpio_pkg::*;
  localparam int NP = 30;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic          wr_en = 1'b0;
  logic [15:0]   addr  = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe, pad_pu;
  logic          irq;

  gpio_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_o(pad_pu), .irq_o(irq)
  );

  // scoreboard: src 0=rdata 1=irq 2=pad_out 3=pad_oe 4=pad_pu
  int          src_q[$];
  int          idx_q[$];
  logic [31:0] exp_q[$];
  string       req_q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam logic [15:0] ST = 16'h0300, MK = 16'h0380;

  function automatic logic [15:0] a0(int p); return pin_word_addr(p, 15, 1'b0); endfunction
  function automatic logic [15:0] a1(int p); return pin_word_addr(p, 15, 1'b1); endfunction

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic set_in(int p, logic v); @(negedge clk); pad_in[p] = v; endtask
  task automatic exp_reg(logic [15:0] a, logic [31:0] e, string r);
    @(negedge clk); wr_en = 1'b0; addr = a;
    src_q.push_back(0); idx_q.push_back(0); exp_q.push_back(e); req_q.push_back(r);
  endtask
  task automatic exp_sig(int s, int i, logic e, string r);
    @(negedge clk);
    src_q.push_back(s); idx_q.push_back(i); exp_q.push_back({31'd0, e}); req_q.push_back(r);
  endtask
  task automatic cfg(int p, logic [31:0] c0, logic [31:0] c1);
    wr(a1(p), c1); wr(a0(p), c0);
  endtask
  task automatic summary; $display("CHECKS %0d ERRORS %0d", checks, errors); endtask

  initial begin : monitor
    forever begin
      int s; int i; logic [31:0] e; logic [31:0] act; string r;
      @(negedge clk); #2;
      while (src_q.size() > 0) begin
        s = src_q.pop_front(); i = idx_q.pop_front();
        e = exp_q.pop_front(); r = req_q.pop_front();
        case (s)
          0: act = rdata;
          1: act = {31'd0, irq};
          2: act = {31'd0, pad_out[i]};
          3: act = {31'd0, pad_oe[i]};
          default: act = {31'd0, pad_pu[i]};
        endcase
        checks++;
        if (act !== e) begin
          errors++;
          $display("FAIL %s src=%0d pin=%0d actual=%h expected=%h", r, s, i, act, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary; $finish;
    end
  end

  initial begin : driver
    idle(3); rst_ni = 1'b1; idle(1);
    // R1 reset state
    exp_reg(ST, 0, "R1"); exp_reg(MK, 0, "R1"); exp_reg(a0(0), 0, "R1");
    exp_reg(a1(29), 0, "R1"); exp_sig(1, 0, 0, "R1"); exp_sig(3, 0, 0, "R1");

    // R2 address map
    wr(16'h4808, 32'h9080_8102);
    exp_reg(a0(16), 32'h9080_8102, "R2");
    wr(16'h4474, 32'h0000_0045);
    exp_reg(16'h4474, 32'h0000_0045, "R2");
    wr(16'h4478, 32'hFFFF_FFFF);
    exp_reg(16'h4478, 0, "R2");
    exp_reg(16'h4470, 0, "R2");
    exp_reg(16'h4800, 0, "R2");

    // R3 field masking and read-only input bit
    wr(a0(20), 32'hFFFF_FFFF);
    exp_reg(a0(20), 32'hF080_8702, "R3");
    wr(a0(2), 32'h0000_8200);
    set_in(2, 1'b1); idle(1);
    exp_reg(a0(2), 32'h0000_8201, "R3");
    set_in(2, 1'b0); idle(2);
    wr(a0(2), 32'h0000_8201);
    exp_reg(a0(2), 32'h0000_8200, "R3");
    set_in(2, 1'b1); wr(a0(2), 32'h0000_8100); idle(2);
    exp_reg(a0(2), 32'h0000_8100, "R3");

    // R4 pad outputs on pin 16 (TX only, tx=1, pull-up)
    exp_sig(3, 16, 1, "R4"); exp_sig(2, 16, 1, "R4"); exp_sig(4, 16, 1, "R4");
    wr(a0(16), 32'h9080_8302); exp_sig(3, 16, 0, "R4");
    wr(a0(16), 32'h9000_8200); exp_sig(3, 16, 0, "R4"); exp_sig(4, 16, 0, "R4");
    wr(a0(16), 32'h9000_0000); exp_sig(3, 16, 0, "R4");
    wr(a0(16), 32'h9000_8000); exp_sig(3, 16, 1, "R4"); exp_sig(2, 16, 0, "R4");
    exp_sig(3, 20, 0, "R4");

    // R5 rising, pin 0 -> line 3
    cfg(0, 32'h3000_8000, 32'h2); wr(ST, 32'hFFFF);
    set_in(0, 1'b1); idle(2); exp_reg(ST, 32'h0008, "R5");
    wr(ST, 32'h0008); set_in(0, 1'b0); idle(4); exp_reg(ST, 0, "R5");

    // R6 falling, pin 1 -> line 4
    cfg(1, 32'h4000_8000, 32'h1); wr(ST, 32'hFFFF);
    set_in(1, 1'b1); idle(4); exp_reg(ST, 0, "R6");
    set_in(1, 1'b0); idle(2); exp_reg(ST, 32'h0010, "R6");

    // R7 both edges, pin 5 -> line 6
    cfg(5, 32'h6000_8000, 32'h3); wr(ST, 32'hFFFF);
    set_in(5, 1'b1); idle(2); exp_reg(ST, 32'h0040, "R7");
    wr(ST, 32'h0040); set_in(5, 1'b0); idle(2); exp_reg(ST, 32'h0040, "R7");

    // R11 mask and interrupt (status bit 6 set)
    exp_sig(1, 0, 0, "R11");
    wr(MK, 32'h0000_0040); exp_sig(1, 0, 1, "R11");
    wr(MK, 32'h0000_0020); exp_sig(1, 0, 0, "R11");
    wr(MK, 32'hFFFF_FFFF); exp_reg(MK, 32'h0000_FFFF, "R11"); exp_sig(1, 0, 1, "R11");
    wr(MK, 32'h0); exp_sig(1, 0, 0, "R11");

    // R8 level, pin 3 -> line 7
    cfg(3, 32'h7000_8000, 32'h4); wr(ST, 32'hFFFF);
    set_in(3, 1'b1); idle(2); exp_reg(ST, 32'h0080, "R8");
    wr(ST, 32'h0080); exp_reg(ST, 32'h0080, "R8");
    set_in(3, 1'b0); idle(3); exp_reg(ST, 32'h0080, "R8");
    wr(ST, 32'h0080); exp_reg(ST, 0, "R8");

    // R9 inverted level (active low), pin 4 -> line 8
    set_in(4, 1'b1); idle(2);
    cfg(4, 32'h8000_8000, 32'h44); wr(ST, 32'hFFFF); idle(2);
    exp_reg(ST, 0, "R9");
    set_in(4, 1'b0); idle(2); exp_reg(ST, 32'h0100, "R9");

    // R10 write-1-to-clear
    set_in(4, 1'b1); idle(3);
    wr(ST, 32'h0000); exp_reg(ST, 32'h0100, "R10");
    wr(ST, 32'h0001); exp_reg(ST, 32'h0100, "R10");
    wr(ST, 32'h0100); exp_reg(ST, 0, "R10");

    // R12 shared line, pins 6 and 7 -> line 10
    cfg(6, 32'hA000_8000, 32'h2); cfg(7, 32'hA000_8000, 32'h2); wr(ST, 32'hFFFF);
    set_in(6, 1'b1); idle(2); exp_reg(ST, 32'h0400, "R12");
    wr(ST, 32'hFFFF);
    set_in(7, 1'b1); idle(2); exp_reg(ST, 32'h0400, "R12");
    set_in(6, 1'b0); set_in(7, 1'b0); wr(ST, 32'hFFFF);
    @(negedge clk); pad_in[6] = 1'b1; pad_in[7] = 1'b1; idle(2);
    exp_reg(ST, 32'h0400, "R12");

    // R13 suppression cases
    cfg(8, 32'hB000_8000, 32'h0);
    cfg(9, 32'hC000_8100, 32'h2);
    cfg(10, 32'hD000_0000, 32'h2);
    wr(ST, 32'hFFFF);
    set_in(8, 1'b1); set_in(9, 1'b1); set_in(10, 1'b1); idle(4);
    set_in(8, 1'b0); set_in(9, 1'b0); set_in(10, 1'b0); idle(4);
    exp_reg(ST, 0, "R13");

    idle(2);
    done = 1'b1;
    summary;
    $finish;
  end
endmodule